// File: doc/BRIEF.md
# Programmable Interval Timer with Control Register

This block is an interval timer placed on a simple register bus. It has two 8-bit counting lanes that advance on a common tick. The tick comes from a free-running prescaler on the system clock, or from rising edges on an external timer pin. A mode bit runs the lanes as two independent 8-bit timers or joins them into one 16-bit timer. Each lane, or the joined pair, wraps to zero when it reaches its programmed compare value. Each wrap sets one sticky pending flag, and that flag drives the interrupt request when the interrupt is enabled.

Software starts an exact interval with a single control write. That write clears both counts, restarts the prescaler and drops the pending flag. The counter clear bit acts as a strobe. The pending bit is cleared by writing zero, and writing one to it leaves it as it is.

Top module: `interval_timer`

## Requirements
- R1: After a synchronous active-low reset the control register reads 0x00, both compare registers read 0xFF, the counts are zero and `irq` is low.
- R2: Address 0 is the control register, address 1 the low (A) compare register, address 2 the high (B) compare register, and any other address reads 0. Control bit 7 is the mode bit, bits 6:4 the clock select, bit 3 the clear strobe, bit 2 run enable, bit 1 interrupt enable and bit 0 the pending flag.
- R3: The clock select codes 000, 001 and 010 give one tick on every 256th, 64th and 8th system clock of the 8-bit prescaler count, and code 011 gives a tick on every clock.
- R4: Clock select 111 gives one tick for each rising edge of `ext_tclk`, after a two-flop synchroniser.
- R5: Clock select codes 100, 101 and 110 produce no ticks, so the counts hold.
- R6: In 8-bit mode (bit 7 = 0), each lane counts ticks. On a tick where a lane equals its own compare value, that lane returns to 0 and the pending flag sets.
- R7: In 16-bit mode (bit 7 = 1), the lanes form one count {B,A}. The count compares against {compare B, compare A}, wraps to 0 on a matching tick, and that tick sets the pending flag.
- R8: Writing the control register with bit 3 = 1 zeroes both counts and the prescaler in the next cycle. Bit 3 is not stored and always reads 0.
- R9: A control write with bit 0 = 0 clears the pending flag, and bit 0 = 1 leaves it unchanged. A match sets the flag, and a match wins over a clear-by-zero in the same cycle. A match in the same cycle as a clear strobe is discarded.
- R10: One control write with bit 3 = 1 and bit 0 = 0 clears the counts and the pending flag together. A lane with compare value N then flags after exactly N+1 ticks.
- R11: With run enable (bit 2) at 0 the counts do not change except through the clear strobe.
- R12: `irq` is high exactly when the pending flag is set and the interrupt enable (bit 1) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_tclk | input | 1 | External timer clock pin, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a bus write lasts exactly one cycle and that `bus_addr` and `bus_wdata` are steady around the clock edge. They also assume `ext_tclk` is low enough and high enough for the synchroniser to see each level. The bench drives every input on the falling clock edge, holds `bus_wr` for a single cycle, and toggles `ext_tclk` no faster than once every three clocks. It also issues clear writes at many points in the count, so some of them land on a match cycle.

// File: rtl/it_pkg.sv
// Shared constants for the interval timer: control bit positions,
// register addresses and the clock select encodings.
package it_pkg;
    localparam int CB_MODE   = 7;
    localparam int CB_SEL_HI = 6;
    localparam int CB_SEL_LO = 4;
    localparam int CB_CLR    = 3;
    localparam int CB_RUN    = 2;
    localparam int CB_IEN    = 1;
    localparam int CB_PEND   = 0;

    localparam logic [7:0] CTRL_STORE_MASK = 8'hF6;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CMP0 = 1;

    typedef enum logic [2:0] {
        CS_DIV256 = 3'b000,
        CS_DIV64  = 3'b001,
        CS_DIV8   = 3'b010,
        CS_FULL   = 3'b011,
        CS_EXT    = 3'b111
    } clk_sel_e;
endpackage

// File: rtl/it_tick_gen.sv
// Tick source: a free-running prescaler on the system clock plus a
// synchronised rising-edge detector on the external pin; the select code
// picks one. Assumes ext_in is asynchronous and slower than clk / 2.
module it_tick_gen #(
    parameter int PW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [2:0] sel,
    input  logic       ext_in,
    output logic       tick
);
    import it_pkg::*;

    localparam int W64 = (PW > 6) ? 6 : PW;
    localparam int W8  = (PW > 3) ? 3 : PW;

    logic [PW-1:0] div_q;
    logic [2:0]    sync_q;
    logic          ext_rise;

    // Prescaler: free-running, restarted by the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   div_q <= '0;
        else if (clr) div_q <= '0;
        else          div_q <= div_q + 1'b1;
    end

    // Two-flop synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ext_in};
    end

    assign ext_rise = sync_q[1] & ~sync_q[2];

    // Select the tick from the prescaler taps or the external edge.
    always_comb begin
        case (sel)
            CS_DIV256: tick = &div_q;
            CS_DIV64:  tick = &div_q[W64-1:0];
            CS_DIV8:   tick = &div_q[W8-1:0];
            CS_FULL:   tick = 1'b1;
            CS_EXT:    tick = ext_rise;
            default:   tick = 1'b0;
        endcase
    end

    // R8
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (div_q == '0));

    // R5
    unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[2] && (sel != 3'b111)) |-> !tick);
endmodule

// File: rtl/it_lane.sv
// One counting lane: clears on the strobe, otherwise on an increment
// request either wraps to zero or adds one. Assumes clr has priority.
module it_lane #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          wrap,
    output logic [CW-1:0] cnt
);
    // Count register with clear, wrap and increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (inc)  cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt));

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && wrap && !clr) |=> (cnt == '0));
endmodule

// File: rtl/interval_timer.sv
// Interval timer top: control and compare registers, tick source and
// the counting lanes. Lanes either run apart or chain into one wide
// count. Assumes single-cycle writes on the register bus.
module interval_timer #(
    parameter int CW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          ext_tclk,
    output logic          irq
);
    import it_pkg::*;

    localparam int NL = 2;

    logic [7:0]    ctrl_q;
    logic          pend_q;
    logic [CW-1:0] cmp_q [NL];
    logic [CW-1:0] cnt_w [NL];
    logic [NL-1:0] lane_eq;
    logic [NL-1:0] lane_inc;
    logic [NL-1:0] lane_wrap;
    logic [NL:0]   carry;
    logic          ctrl_wr, clr_stb, mode16, raw_tick, tick, full_eq, hit_ev;

    assign ctrl_wr = bus_wr && (bus_addr == AW'(ADDR_CTRL));
    assign clr_stb = ctrl_wr && bus_wdata[CB_CLR];
    assign mode16  = ctrl_q[CB_MODE];
    assign tick    = raw_tick && ctrl_q[CB_RUN];
    assign full_eq = &lane_eq;
    assign carry[0] = 1'b1;

    it_tick_gen #(.PW(8)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_stb),
        .sel    (ctrl_q[CB_SEL_HI:CB_SEL_LO]),
        .ext_in (ext_tclk),
        .tick   (raw_tick)
    );

    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign lane_eq[i]  = (cnt_w[i] == cmp_q[i]);
        assign carry[i+1]  = carry[i] & (&cnt_w[i]);
        assign lane_inc[i] = mode16 ? (tick && (full_eq || carry[i])) : tick;
        assign lane_wrap[i] = mode16 ? full_eq : lane_eq[i];

        // Compare register for this lane, written at its own address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_q[i] <= '1;
            else if (bus_wr && (bus_addr == AW'(ADDR_CMP0 + i)))
                cmp_q[i] <= bus_wdata[CW-1:0];
        end

        it_lane #(.CW(CW)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_stb),
            .inc   (lane_inc[i]),
            .wrap  (lane_wrap[i]),
            .cnt   (cnt_w[i])
        );
    end

    assign hit_ev = tick && (mode16 ? full_eq : |lane_eq);

    // Stored control bits; the clear strobe and pending are not kept here.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= 8'h00;
        else if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_STORE_MASK;
    end

    // Sticky pending flag: set by a match, cleared by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pend_q <= 1'b0;
        else if (hit_ev && !clr_stb)             pend_q <= 1'b1;
        else if (ctrl_wr && !bus_wdata[CB_PEND]) pend_q <= 1'b0;
    end

    // Read mux over the register map.
    always_comb begin
        if (bus_addr == AW'(ADDR_CTRL))
            bus_rdata = ctrl_q | {7'b0, pend_q};
        else if (bus_addr == AW'(ADDR_CMP0))
            bus_rdata = 8'(cmp_q[0]);
        else if (bus_addr == AW'(ADDR_CMP0 + 1))
            bus_rdata = 8'(cmp_q[1]);
        else
            bus_rdata = 8'h00;
    end

    assign irq = pend_q && ctrl_q[CB_IEN];

    // R9
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(hit_ev && !clr_stb));

    // R9
    pend_wr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[CB_PEND] && !hit_ev) |=> !pend_q);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((cnt_w[0] == '0) && (cnt_w[1] == '0)));

    // R7
    wide_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode16 && tick && full_eq && !clr_stb) |=> ((cnt_w[0] == '0) && (cnt_w[1] == '0) && pend_q));
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_tclk = 1'b0;
    logic       irq;

    int checks = 0;
    int fails = 0;
    string tag = "R1";
    bit done = 0;

    // reference model state
    int m_div, m_a, m_b;
    logic [7:0] m_ctrl, m_da, m_db;
    bit m_pend, s1, s2, s3;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer u_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tclk(ext_tclk), .irq(irq)
    );

    // behavioural model, advanced on every rising edge from the inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_a = 0; m_b = 0; m_ctrl = 8'h00; m_da = 8'hFF; m_db = 8'hFF;
            m_pend = 0; s1 = 0; s2 = 0; s3 = 0;
        end else begin
            bit tk, clr, hit, wctl;
            int sel, c, m;
            sel = (m_ctrl >> 4) & 7;
            case (sel)
                0: tk = (m_div == 255);
                1: tk = (m_div % 64 == 63);
                2: tk = (m_div % 8 == 7);
                3: tk = 1;
                7: tk = s2 && !s3;
                default: tk = 0;
            endcase
            if (!m_ctrl[2]) tk = 0;
            wctl = bus_wr && bus_addr == 0;
            clr = wctl && bus_wdata[3];
            hit = 0;
            if (clr) begin
                m_a = 0; m_b = 0;
            end else if (tk) begin
                if (m_ctrl[7]) begin
                    c = m_b * 256 + m_a;
                    m = int'(m_db) * 256 + int'(m_da);
                    if (c == m) begin c = 0; hit = 1; end
                    else c = (c + 1) % 65536;
                    m_a = c % 256; m_b = c / 256;
                end else begin
                    if (m_a == int'(m_da)) begin m_a = 0; hit = 1; end else m_a = m_a + 1;
                    if (m_b == int'(m_db)) begin m_b = 0; hit = 1; end else m_b = m_b + 1;
                end
            end
            if (hit && !clr) m_pend = 1;
            else if (wctl && !bus_wdata[0]) m_pend = 0;
            m_div = clr ? 0 : (m_div + 1) % 256;
            s3 = s2; s2 = s1; s1 = ext_tclk;
            if (wctl) m_ctrl = bus_wdata & 8'hF6;
            if (bus_wr && bus_addr == 1) m_da = bus_wdata;
            if (bus_wr && bus_addr == 2) m_db = bus_wdata;
        end
    end

    task automatic chk(string r, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", r, got, exp);
        end
    endtask

    // per-cycle comparison against the model, at the falling edge
    task automatic step();
        logic [7:0] er;
        @(negedge clk);
        case (bus_addr)
            2'd0: er = m_ctrl | {7'b0, m_pend};
            2'd1: er = m_da;
            2'd2: er = m_db;
            default: er = 8'h00;
        endcase
        chk({tag, " rdata"}, bus_rdata, er);
        chk({tag, " irq"}, irq, m_pend && m_ctrl[1]);
    endtask

    task automatic wr(int a, int d);
        bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        step();
        bus_wr = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        tag = "R1";
        step();
        chk("R1 ctrl", bus_rdata, 8'h00);
        chk("R1 irq", irq, 0);
        bus_addr = 2'd1; step(); chk("R1 cmpA", bus_rdata, 8'hFF);
        bus_addr = 2'd0;
        // R2 register map
        tag = "R2";
        wr(1, 5); wr(2, 9);
        bus_addr = 2'd1; step(); chk("R2 cmpA", bus_rdata, 5);
        bus_addr = 2'd2; step(); chk("R2 cmpB", bus_rdata, 9);
        bus_addr = 2'd3; step(); chk("R2 unused", bus_rdata, 0);
        bus_addr = 2'd0;
        // R6 8-bit mode, undivided clock
        tag = "R6";
        wr(0, 8'h36); run(40);
        chk("R6 irq", irq, 1);
        // R9 clear by zero, write one has no effect; R11 run off holds
        tag = "R9";
        wr(0, 8'h32); step(); chk("R9 clear", bus_rdata[0], 0);
        wr(0, 8'h33); step(); chk("R9 w1 no effect", bus_rdata[0], 0);
        tag = "R11";
        run(50); chk("R11 stopped", irq, 0);
        tag = "R9";
        wr(0, 8'h36); run(20); wr(0, 8'h33); step();
        chk("R9 w1 keeps", bus_rdata[0], 1);
        // R8 clear strobe and collisions with matches
        tag = "R8";
        for (int k = 0; k < 14; k++) begin
            wr(0, 8'h3E); run(k % 7);
        end
        step(); chk("R8 bit3 reads 0", bus_rdata[3], 0);
        // R10 exact interval: six ticks after the start write
        tag = "R10";
        wr(0, 8'h3E); run(4); chk("R10 early", irq, 0);
        step(); step(); chk("R10 on time", irq, 1);
        // R3 prescaler taps
        tag = "R3";
        wr(1, 1); wr(2, 2);
        wr(0, 8'h0E); run(1200);
        wr(0, 8'h1E); run(400);
        wr(0, 8'h2E); run(120);
        // R4 external clock
        tag = "R4";
        wr(0, 8'h7E);
        for (int k = 0; k < 40; k++) begin ext_tclk = ~ext_tclk; run(3 + k % 3); end
        chk("R4 irq", irq, 1);
        // R5 unused codes
        tag = "R5";
        for (int s = 4; s < 7; s++) begin
            wr(0, (s << 4) | 8'h0E); run(300);
            chk("R5 no tick", irq, 0);
        end
        // R7 16-bit mode, compare 0x0103
        tag = "R7";
        wr(1, 3); wr(2, 1); wr(0, 8'hBE);
        run(259); chk("R7 early", irq, 0);
        step(); chk("R7 on time", irq, 1);
        run(600);
        // R12 interrupt enable gates irq
        tag = "R12";
        wr(0, 8'hB4); run(300);
        chk("R12 irq masked", irq, 0);
        chk("R12 pend set", bus_rdata[0], 1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule